// File: doc/BRIEF.md
# Serial Coefficient Write Port

This block is a receive-only two-wire serial slave that loads 16-bit coefficient words into an internal RAM. It watches a synchronously sampled clock/data pair, matches a 7-bit device address whose two low bits come from strap pins, then takes one byte as the starting RAM location. Each coefficient follows as a pair of bytes, high byte first. After every complete word the block fires a RAM write strobe and advances the location by one.

A transfer can carry at most a parameterised number of words (four by default). When the starting location is the mode register address, only a single word is accepted. Bytes beyond the allowed count receive no acknowledge and cause no write. A device address that does not match makes the block release the data line and ignore the bus until the next START.

The RAM write port has no back-pressure. The serial master cannot be held off, because clock stretching is not supported. The sink must therefore accept every cycle in which `wr_en` is high. Each such cycle carries a complete word, and the strobe never lasts longer than one cycle.

Top module: `coef_i2c_loader`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe` is 0 and `wr_en` is 0.
- R2: A first byte after START equal to {0,0,1,1,0,`sel_pins[1]`,`sel_pins[0]`,0} (MSB first, last bit the direction bit, 0 = write) is acknowledged: `sda_oe` is 1 during the ninth SCL pulse.
- R3: A first byte that differs from the R2 pattern is not acknowledged, whether in a strap bit or in the direction bit. All following bytes up to the next START are then not acknowledged and produce no write.
- R4: The second byte is acknowledged and becomes the RAM location of the first word.
- R5: Each word is received high byte first, with every data byte acknowledged. After the low byte `wr_en` is high for exactly one cycle with `wr_data` = {high, low}.
- R6: The RAM location rises by one after every written word and wraps from 8'hFF to 8'h00.
- R7: At most MAX_WORDS (default 4) words are written per transfer. The first byte past that limit, and every byte after it, is not acknowledged and produces no write.
- R8: When the location byte equals MODE_ADDR (default 8'h7E), only one word is written. The next data byte is not acknowledged.
- R9: A STOP after only the high byte of a word produces no write, and the next transfer works normally.
- R10: A repeated START in the middle of a transfer restarts at the device-address byte. Only words of the new frame are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sel_pins | input | 2 | Strap bits of the device address |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |
| wr_addr | output | 8 | RAM write location |
| wr_data | output | 16 | RAM write word |
| wr_en | output | 1 | RAM write strobe, one cycle per word |

## Verification
Each line passes through two synchroniser flops and one edge-detect stage, and every output is registered. The acknowledge pull-down and the write strobe therefore change two to three system clocks after the SCL falling edge that ends a byte. The bench holds every SCL phase for six system clocks, so the acknowledge level is sampled on the resolved data line at the end of the ninth high phase, well after it has settled. Write strobes are collected by a monitor on the falling clock edge and compared against the expected location and word list once each transfer has ended with STOP.

// File: rtl/coefl_pkg.sv
package coefl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/coefl_sync.sv
module coefl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      scl_q     <= scl_ff[STAGES-1];
      sda_q     <= sda_ff[STAGES-1];
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else begin
        scl_ff[g] <= scl_ff[g-1];
        sda_ff[g] <= sda_ff[g-1];
      end
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/coefl_byte.sv
module coefl_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  output logic       byte_done,
  output logic       ack_end,
  output logic [7:0] rx_byte
);
  logic [3:0] cnt_q;
  logic       in_ack_q;

  assign byte_done = scl_fall && (cnt_q == 4'd8) && !in_ack_q;
  assign ack_end   = scl_fall && in_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      rx_byte  <= '0;
    end else if (clr) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else begin
      if (scl_rise && cnt_q < 4'd8) begin
        rx_byte <= {rx_byte[6:0], sda_lvl};
        cnt_q   <= cnt_q + 4'd1;
      end
      if (byte_done) in_ack_q <= 1'b1;
      if (ack_end) begin
        in_ack_q <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd8);
endmodule

// File: rtl/coefl_ctrl.sv
module coefl_ctrl
  import coefl_pkg::*;
#(
  parameter int          MAX_WORDS = 4,
  parameter logic [7:0]  MODE_ADDR = 8'h7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sel_pins,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        scl_lvl,
  input  logic        byte_done,
  input  logic        ack_end,
  input  logic [7:0]  rx_byte,
  output logic        sda_oe,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        wr_en
);
  localparam int         WCW     = $clog2(MAX_WORDS + 1);
  localparam logic [4:0] DEV_TOP = 5'b00110;

  phase_t           phase_q;
  logic [7:0]       ptr_q, hi_q;
  logic             hi_have_q, mode_q;
  logic [WCW-1:0]   words_q;
  logic             dev_hit, room;

  assign dev_hit = (rx_byte == {DEV_TOP, sel_pins, 1'b0});
  assign room    = mode_q ? (words_q == '0) : (words_q < WCW'(MAX_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ptr_q     <= '0;
      hi_q      <= '0;
      hi_have_q <= 1'b0;
      mode_q    <= 1'b0;
      words_q   <= '0;
      sda_oe    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_en     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase_q <= PH_DEV;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        phase_q <= PH_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        if (ack_end) sda_oe <= 1'b0;
        if (byte_done) begin
          case (phase_q)
            PH_DEV: begin
              if (dev_hit) begin
                sda_oe  <= 1'b1;
                phase_q <= PH_REG;
              end else begin
                phase_q <= PH_SKIP;
              end
            end
            PH_REG: begin
              sda_oe    <= 1'b1;
              ptr_q     <= rx_byte;
              mode_q    <= (rx_byte == MODE_ADDR);
              words_q   <= '0;
              hi_have_q <= 1'b0;
              phase_q   <= PH_DATA;
            end
            PH_DATA: begin
              if (!room) begin
                phase_q <= PH_SKIP;
              end else begin
                sda_oe <= 1'b1;
                if (!hi_have_q) begin
                  hi_q      <= rx_byte;
                  hi_have_q <= 1'b1;
                end else begin
                  wr_en     <= 1'b1;
                  wr_addr   <= ptr_q;
                  wr_data   <= {hi_q, rx_byte};
                  ptr_q     <= ptr_q + 8'd1;
                  words_q   <= words_q + 1'b1;
                  hi_have_q <= 1'b0;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_ack_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> (!sda_oe && !wr_en));
  p_word_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (words_q <= WCW'(MAX_WORDS)));
  p_mode_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && phase_q == PH_DATA) |-> (words_q <= WCW'(1)));
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

// File: rtl/coef_i2c_loader.sv
module coef_i2c_loader #(
  parameter int         SYNC_STAGES = 2,
  parameter int         MAX_WORDS   = 4,
  parameter logic [7:0] MODE_ADDR   = 8'h7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  sel_pins,
  output logic        sda_oe,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        wr_en
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_end;
  logic [7:0] rx_byte;

  coefl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  coefl_byte u_byte (
    .clk(clk), .rst_n(rst_n), .clr(start_det | stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .byte_done(byte_done), .ack_end(ack_end), .rx_byte(rx_byte)
  );

  coefl_ctrl #(.MAX_WORDS(MAX_WORDS), .MODE_ADDR(MODE_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins),
    .start_det(start_det), .stop_det(stop_det), .scl_lvl(scl_lvl),
    .byte_done(byte_done), .ack_end(ack_end), .rx_byte(rx_byte),
    .sda_oe(sda_oe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !wr_en));
endmodule

// File: tb/sim_coef_i2c_loader.sv
module sim_coef_i2c_loader;
  localparam int CLK_NS = 10;
  localparam int Q      = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] sel = 2'b10;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int log_n = 0;
  logic [7:0]  log_a [64];
  logic [15:0] log_d [64];
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  coef_i2c_loader u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel_pins(sel), .sda_oe(sda_oe), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en)
  );

  always @(negedge clk) begin
    if (wr_en && log_n < 64) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n = log_n + 1;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_n(Q);
    scl = 1'b1;   wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl = 1'b0;   wait_n(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_n(Q);
    scl = 1'b1;   wait_n(Q);
    sda_m = 1'b1; wait_n(4 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_n(Q);
      scl = 1'b1;   wait_n(Q);
      scl = 1'b0;   wait_n(Q);
    end
    sda_m = 1'b1; wait_n(Q);
    scl = 1'b1;   wait_n(Q);
    acked = !sda_line;
    scl = 1'b0;   wait_n(Q);
  endtask

  task automatic send_word(input logic [15:0] w, input string tag, input int exp_ack);
    bit a;
    send_byte(w[15:8], a); chk({tag, " hi ack"}, a, exp_ack);
    send_byte(w[7:0], a);  chk({tag, " lo ack"}, a, exp_ack);
  endtask

  task automatic open_frame(input logic [7:0] dev, input logic [7:0] loc,
                            input int exp_ack, input string tag);
    bit a;
    i2c_start();
    send_byte(dev, a); chk({tag, " R2 dev ack"}, a, exp_ack);
    send_byte(loc, a); chk({tag, " R4 loc ack"}, a, exp_ack);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wait_n(3);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 wr_en in reset", wr_en, 0);
    rst_n = 1'b1; wait_n(4);
    chk("R1 sda_oe after reset", sda_oe, 0);
  endtask

  task automatic t_basic();
    log_n = 0;
    open_frame(8'h34, 8'h10, 1, "basic");
    send_word(16'h1234, "R5 w0", 1);
    send_word(16'hABCD, "R5 w1", 1);
    i2c_stop();
    chk("R5 count", log_n, 2);
    chk("R4 first loc", log_a[0], 8'h10);
    chk("R5 first data", log_d[0], 16'h1234);
    chk("R6 second loc", log_a[1], 8'h11);
    chk("R5 second data", log_d[1], 16'hABCD);
  endtask

  task automatic t_other_sel();
    log_n = 0; sel = 2'b01;
    open_frame(8'h32, 8'h20, 1, "sel01");
    send_word(16'h0F0F, "R2 sel01 w", 1);
    i2c_stop();
    chk("R2 sel01 count", log_n, 1);
    chk("R2 sel01 data", log_d[0], 16'h0F0F);
    sel = 2'b10;
  endtask

  task automatic t_bad_dev(input logic [7:0] dev, input string tag);
    log_n = 0;
    open_frame(dev, 8'h10, 0, {"R3 ", tag});
    send_word(16'h5566, {"R3 ", tag}, 0);
    i2c_stop();
    chk({"R3 ", tag, " no write"}, log_n, 0);
  endtask

  task automatic t_limit();
    log_n = 0;
    open_frame(8'h34, 8'h50, 1, "limit");
    for (int k = 0; k < 4; k++) send_word(16'hA000 + 16'(k), "R7 in", 1);
    send_word(16'hBEEF, "R7 over", 0);
    i2c_stop();
    chk("R7 count", log_n, 4);
    chk("R7 last loc", log_a[3], 8'h53);
    chk("R7 last data", log_d[3], 16'hA003);
  endtask

  task automatic t_mode();
    log_n = 0;
    open_frame(8'h34, 8'h7E, 1, "mode");
    send_word(16'h00C3, "R8 first", 1);
    send_word(16'h1111, "R8 second", 0);
    i2c_stop();
    chk("R8 count", log_n, 1);
    chk("R8 loc", log_a[0], 8'h7E);
    chk("R8 data", log_d[0], 16'h00C3);
  endtask

  task automatic t_wrap();
    log_n = 0;
    open_frame(8'h34, 8'hFE, 1, "wrap");
    for (int k = 0; k < 4; k++) send_word(16'h7700 + 16'(k), "R6 wrap", 1);
    i2c_stop();
    chk("R6 count", log_n, 4);
    chk("R6 loc 1", log_a[1], 8'hFF);
    chk("R6 loc 2 wrapped", log_a[2], 8'h00);
    chk("R6 loc 3", log_a[3], 8'h01);
  endtask

  task automatic t_half();
    bit a;
    log_n = 0;
    open_frame(8'h34, 8'h30, 1, "half");
    send_byte(8'h99, a); chk("R9 hi ack", a, 1);
    i2c_stop();
    chk("R9 no write on partial", log_n, 0);
    open_frame(8'h34, 8'h31, 1, "half2");
    send_word(16'h4242, "R9 after", 1);
    i2c_stop();
    chk("R9 next count", log_n, 1);
    chk("R9 next loc", log_a[0], 8'h31);
  endtask

  task automatic t_restart();
    bit a;
    log_n = 0;
    open_frame(8'h34, 8'h20, 1, "rs1");
    send_byte(8'hDE, a); chk("R10 hi ack", a, 1);
    open_frame(8'h34, 8'h40, 1, "rs2");
    send_word(16'h600D, "R10 new", 1);
    i2c_stop();
    chk("R10 count", log_n, 1);
    chk("R10 loc", log_a[0], 8'h40);
    chk("R10 data", log_d[0], 16'h600D);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_other_sel();
    t_bad_dev(8'h36, "strap");
    t_bad_dev(8'h35, "read");
    t_basic();
    t_limit();
    t_mode();
    t_wrap();
    t_half();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule